// File: doc/BRIEF.md
# Virtual JTAG Node Hub

The hub sits behind a physical JTAG TAP and shares one pair of user instructions among several internal nodes. A decoded "virtual IR scan" flag makes every DR scan target a virtual instruction register. This register holds an address field in its upper bits and a value field in its lower bits. A decoded "virtual DR scan" flag routes later DR scans to the node named by the stored address. The TAP's capture, shift and update strobes drive the hub directly.

Address 0 names the hub itself. With value 0, the hub's data register returns a self-description that software uses to size the virtual IR and to find each node. First comes a configuration word, then one descriptor word per node in address order. Each 32-bit word is read as eight 4-bit DR scans, least significant nibble first. Each scan is closed by an update before the next capture.

When the virtual IR is written with the address of a real node, the value field goes to that node's IR port together with a one-cycle strobe. The TDO output comes from the LSB of whichever shift path is currently selected.

Top module: `vjtag_hub`

## Requirements
- R1: After reset, and in the cycle after `tlr` is high, the stored virtual IR is address 0, value 0. A following virtual IR capture and shift returns all zeros.
- R2: With `vir_scan_en` high, `capture_dr` loads the stored virtual IR into a shift register of width n+m. Here n = ceil(log2(NODES+1)) and the address is the upper n bits. Each `shift_dr` moves `tdi` into the MSB. `tdo` shows the current LSB. `update_dr` stores the shift register as the new virtual IR.
- R3: A virtual IR update with address a, where 1 ≤ a ≤ NODES, copies the value field into `node_ir[(a-1)*M_W +: M_W]`. In the next cycle it raises `node_ir_upd[a-1]` for exactly one cycle. The other slices are unchanged.
- R4: A virtual IR update with address 0, or with an address above NODES, raises no strobe and changes no `node_ir` slice.
- R5: With `vdr_scan_en` high and a node address stored, `node_sel` is one-hot for that node and `tdo` equals that node's `node_tdo` bit. `node_tdi` always equals `tdi`. `node_sel` is zero whenever `vdr_scan_en` is low.
- R6: With `vdr_scan_en` high and the stored virtual IR equal to address 0, value 0, `capture_dr` loads the current nibble. Four shifts present it on `tdo` LSB first, and `update_dr` advances to the next nibble.
- R7: Word 0 of the readout is {hub version[31:27], NODES[26:19], manufacturer 0x06E[18:8], M_W[7:0]}.
- R8: Words 1..NODES are the node descriptors in address order. After the last nibble of the last word, the readout wraps to nibble 0 of word 0.
- R9: After any virtual IR update or `tlr`, the next hub readout capture starts again at nibble 0 of word 0. Without such an event, the readout continues from where it stopped.
- R10: `tdo` is 0 when neither scan flag is high. It is also 0 in a virtual DR scan when the hub is addressed with a nonzero value, or when the address is above NODES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| vir_scan_en | input | 1 | User instruction selecting the virtual IR is active |
| vdr_scan_en | input | 1 | User instruction selecting the addressed data register is active |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| node_tdo | input | NODES | Serial data from each node |
| node_tdi | output | 1 | Serial data to the nodes |
| node_sel | output | NODES | One-hot node data-scan select |
| node_ir | output | NODES*M_W | Virtual IR value held for each node |
| node_ir_upd | output | NODES | One-cycle strobe per node on an IR write |

## Verification
The bench builds the hub with two nodes and a 4-bit value field. This gives a 2-bit address, so address 3 is a legal encoding that names no node, which reaches the out-of-range case of R4 and R10. Three words make a 24-nibble readout, short enough to run past the end and see the wrap. The readout is also cut off mid-word and then restarted, both by a virtual IR rewrite and by Test-Logic-Reset.

// File: rtl/vjtag_hub_pkg.sv
package vjtag_hub_pkg;
    localparam logic [10:0] MFG_ID = 11'h06E;

    // Width of the address field: enough to name the hub plus every node.
    function automatic int addr_bits(input int nodes);
        return $clog2(nodes + 1);
    endfunction
endpackage

// File: rtl/vjtag_vir.sv
module vjtag_vir #(
    parameter int NODES = 2,
    parameter int M_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tlr,
    input  logic                          scan_en,
    input  logic                          capture,
    input  logic                          shift,
    input  logic                          update,
    input  logic                          tdi,
    output logic [vjtag_hub_pkg::addr_bits(NODES)-1:0] vir_addr,
    output logic [M_W-1:0]                vir_val,
    output logic                          sh_lsb,
    output logic [NODES*M_W-1:0]          node_ir,
    output logic [NODES-1:0]              node_upd
);
    localparam int A_W = vjtag_hub_pkg::addr_bits(NODES);
    localparam int V_W = A_W + M_W;

    typedef struct packed {
        logic [V_W-1:0]       vir;
        logic [V_W-1:0]       sh;
        logic [NODES*M_W-1:0] nir;
        logic [NODES-1:0]     upd;
    } vir_st_t;

    vir_st_t st_d, st_q;
    logic [NODES-1:0] hit;

    // Address decode of the pending shift contents, one comparator per node.
    for (genvar g = 0; g < NODES; g++) begin : g_hit
        assign hit[g] = (st_q.sh[V_W-1:M_W] == A_W'(g + 1));
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = '0;
        if (tlr) begin
            st_d.vir = '0;
        end else if (scan_en) begin
            if (capture) begin
                st_d.sh = st_q.vir;
            end else if (shift) begin
                st_d.sh = {tdi, st_q.sh[V_W-1:1]};
            end else if (update) begin
                st_d.vir = st_q.sh;
                st_d.upd = hit;
                for (int i = 0; i < NODES; i++) begin
                    if (hit[i]) st_d.nir[i*M_W +: M_W] = st_q.sh[M_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vir_addr = st_q.vir[V_W-1:M_W];
    assign vir_val  = st_q.vir[M_W-1:0];
    assign sh_lsb   = st_q.sh[0];
    assign node_ir  = st_q.nir;
    assign node_upd = st_q.upd;
endmodule

// File: rtl/vjtag_info.sv
module vjtag_info #(
    parameter int                    NODES     = 2,
    parameter int                    M_W       = 4,
    parameter int                    HUB_VER   = 1,
    parameter logic [NODES*32-1:0]   NODE_DESC = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tlr,
    input  logic restart,
    input  logic active,
    input  logic capture,
    input  logic shift,
    input  logic update,
    output logic sh_lsb
);
    localparam int NIBS  = (NODES + 1) * 8;
    localparam int PTR_W = $clog2(NIBS);
    localparam logic [31:0] CFG_WORD =
        {5'(HUB_VER), 8'(NODES), vjtag_hub_pkg::MFG_ID, 8'(M_W)};
    localparam logic [(NODES+1)*32-1:0] INFO = {NODE_DESC, CFG_WORD};
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NIBS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [3:0]       sh;
        logic             fresh;
    } info_st_t;

    info_st_t st_d, st_q;
    logic [PTR_W-1:0] cap_ptr;
    logic [PTR_W+1:0] bit_pos;

    always_comb begin
        st_d    = st_q;
        cap_ptr = st_q.fresh ? '0 : st_q.ptr;
        bit_pos = {cap_ptr, 2'b00};
        if (tlr) begin
            st_d.fresh = 1'b1;
            st_d.ptr   = '0;
        end else begin
            if (restart) st_d.fresh = 1'b1;
            if (active) begin
                if (capture) begin
                    st_d.ptr   = cap_ptr;
                    st_d.sh    = INFO[bit_pos +: 4];
                    st_d.fresh = 1'b0;
                end else if (shift) begin
                    st_d.sh = {1'b0, st_q.sh[3:1]};
                end else if (update) begin
                    st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ptr: '0, sh: '0, fresh: 1'b1};
        else        st_q <= st_d;
    end

    assign sh_lsb = st_q.sh[0];
endmodule

// File: rtl/vjtag_route.sv
module vjtag_route #(
    parameter int NODES = 2,
    parameter int M_W   = 4
) (
    input  logic                          vir_scan_en,
    input  logic                          vdr_scan_en,
    input  logic [vjtag_hub_pkg::addr_bits(NODES)-1:0] vir_addr,
    input  logic [M_W-1:0]                vir_val,
    input  logic                          vir_lsb,
    input  logic                          info_lsb,
    input  logic [NODES-1:0]              node_tdo,
    output logic [NODES-1:0]              node_sel,
    output logic                          tdo
);
    localparam int A_W = vjtag_hub_pkg::addr_bits(NODES);

    always_comb begin
        node_sel = '0;
        tdo      = 1'b0;
        if (vir_scan_en) begin
            tdo = vir_lsb;
        end else if (vdr_scan_en) begin
            if (vir_addr == '0) begin
                tdo = (vir_val == '0) ? info_lsb : 1'b0;
            end else begin
                for (int i = 0; i < NODES; i++) begin
                    if (vir_addr == A_W'(i + 1)) begin
                        node_sel[i] = 1'b1;
                        tdo         = node_tdo[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vjtag_hub.sv
module vjtag_hub #(
    parameter int                  NODES     = 2,
    parameter int                  M_W       = 4,
    parameter int                  HUB_VER   = 1,
    parameter logic [NODES*32-1:0] NODE_DESC = {32'h14206E01, 32'h08406E00}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tlr,
    input  logic                 vir_scan_en,
    input  logic                 vdr_scan_en,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 tdi,
    output logic                 tdo,
    input  logic [NODES-1:0]     node_tdo,
    output logic                 node_tdi,
    output logic [NODES-1:0]     node_sel,
    output logic [NODES*M_W-1:0] node_ir,
    output logic [NODES-1:0]     node_ir_upd
);
    localparam int A_W = vjtag_hub_pkg::addr_bits(NODES);

    logic [A_W-1:0] vir_addr;
    logic [M_W-1:0] vir_val;
    logic           vir_lsb;
    logic           info_lsb;
    logic           hub_info_sel;

    assign hub_info_sel = (vir_addr == '0) && (vir_val == '0);
    assign node_tdi     = tdi;

    vjtag_vir #(.NODES(NODES), .M_W(M_W)) u_vir (
        .clk      (clk),
        .rst_n    (rst_n),
        .tlr      (tlr),
        .scan_en  (vir_scan_en),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .update   (update_dr),
        .tdi      (tdi),
        .vir_addr (vir_addr),
        .vir_val  (vir_val),
        .sh_lsb   (vir_lsb),
        .node_ir  (node_ir),
        .node_upd (node_ir_upd)
    );

    vjtag_info #(
        .NODES(NODES), .M_W(M_W), .HUB_VER(HUB_VER), .NODE_DESC(NODE_DESC)
    ) u_info (
        .clk     (clk),
        .rst_n   (rst_n),
        .tlr     (tlr),
        .restart (vir_scan_en & update_dr),
        .active  (vdr_scan_en & hub_info_sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .update  (update_dr),
        .sh_lsb  (info_lsb)
    );

    vjtag_route #(.NODES(NODES), .M_W(M_W)) u_route (
        .vir_scan_en (vir_scan_en),
        .vdr_scan_en (vdr_scan_en),
        .vir_addr    (vir_addr),
        .vir_val     (vir_val),
        .vir_lsb     (vir_lsb),
        .info_lsb    (info_lsb),
        .node_tdo    (node_tdo),
        .node_sel    (node_sel),
        .tdo         (tdo)
    );
endmodule

// File: rtl/vjtag_hub_chk.sv
module vjtag_hub_chk #(
    parameter int NODES = 2,
    parameter int M_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tlr,
    input logic                 vir_scan_en,
    input logic                 vdr_scan_en,
    input logic                 update_dr,
    input logic                 tdo,
    input logic [NODES-1:0]     node_sel,
    input logic [NODES*M_W-1:0] node_ir,
    input logic [NODES-1:0]     node_ir_upd,
    input logic [vjtag_hub_pkg::addr_bits(NODES)-1:0] vir_addr,
    input logic [M_W-1:0]       vir_val
);
    // R1
    tlr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlr |=> (vir_addr == '0 && vir_val == '0));

    // R3
    upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(node_ir_upd));

    // R3
    upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|node_ir_upd) |-> $past(vir_scan_en && update_dr && !tlr));

    // R4
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|node_ir_upd) |-> $stable(node_ir));

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(node_sel));

    // R5
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|node_sel) |-> vdr_scan_en);

    // R10
    idle_tdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vir_scan_en && !vdr_scan_en) |-> !tdo);
endmodule

bind vjtag_hub vjtag_hub_chk #(.NODES(NODES), .M_W(M_W)) u_hub_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tlr         (tlr),
    .vir_scan_en (vir_scan_en),
    .vdr_scan_en (vdr_scan_en),
    .update_dr   (update_dr),
    .tdo         (tdo),
    .node_sel    (node_sel),
    .node_ir     (node_ir),
    .node_ir_upd (node_ir_upd),
    .vir_addr    (vir_addr),
    .vir_val     (vir_val)
);

// File: tb/test_vjtag_hub.sv
`timescale 1ns/1ps
module test_vjtag_hub;
    localparam int NODES = 2;
    localparam int MW    = 4;
    localparam int HVER  = 1;
    localparam logic [31:0] DESC1 = 32'h08406E00;
    localparam logic [31:0] DESC2 = 32'h14206E01;

    logic clk = 1'b0;
    logic rst_n = 1'b0, tlr = 1'b0, vir_en = 1'b0, vdr_en = 1'b0;
    logic cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic [NODES-1:0] ntdo = '0;
    logic tdo, node_tdi;
    logic [NODES-1:0] node_sel, node_ir_upd;
    logic [NODES*MW-1:0] node_ir;

    int checks = 0, fails = 0;
    bit done = 0;

    // Test-side mode, copied onto the pins by cyc().
    bit md_vir = 0, md_vdr = 0, md_tlr = 0;
    logic [NODES-1:0] md_ntdo = '0;
    logic last_tdo;
    logic [NODES-1:0] last_upd;

    always #2 clk = ~clk;

    vjtag_hub #(.NODES(NODES), .M_W(MW), .HUB_VER(HVER), .NODE_DESC({DESC2, DESC1})) i_vjtag_hub (
        .clk(clk), .rst_n(rst_n), .tlr(tlr), .vir_scan_en(vir_en), .vdr_scan_en(vdr_en),
        .capture_dr(cap), .shift_dr(shf), .update_dr(upd), .tdi(tdi), .tdo(tdo),
        .node_tdo(ntdo), .node_tdi(node_tdi), .node_sel(node_sel),
        .node_ir(node_ir), .node_ir_upd(node_ir_upd));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input int k);
        if (k == 0) return (32'(HVER) << 27) | (32'(NODES) << 19) | (32'h06E << 8) | 32'(MW);
        return (k == 1) ? DESC1 : DESC2;
    endfunction

    // ---------------- reference model ----------------
    int m_addr = 0, m_val = 0, m_ptr = 0;
    bit m_fresh = 1;
    bit vq[$];
    bit nq[$];
    int m_nir[NODES];
    bit m_upd[NODES];

    initial begin
        for (int b = 0; b < 6; b++) vq.push_back(1'b0);
        for (int b = 0; b < 4; b++) nq.push_back(1'b0);
        for (int i = 0; i < NODES; i++) begin m_nir[i] = 0; m_upd[i] = 0; end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NODES; i++) m_upd[i] = 0;
            if (tlr) begin
                m_addr = 0; m_val = 0; m_fresh = 1; m_ptr = 0;
            end else if (vir_en) begin
                if (cap) begin
                    vq.delete();
                    for (int b = 0; b < 6; b++) vq.push_back(bit'(((m_addr * 16 + m_val) >> b) & 1));
                end else if (shf) begin
                    void'(vq.pop_front());
                    vq.push_back(bit'(tdi));
                end else if (upd) begin
                    int v;
                    v = 0;
                    for (int b = 0; b < 6; b++) v += int'(vq[b]) << b;
                    m_addr = v / 16; m_val = v % 16; m_fresh = 1;
                    if (m_addr >= 1 && m_addr <= NODES) begin
                        m_nir[m_addr-1] = m_val;
                        m_upd[m_addr-1] = 1;
                    end
                end
            end else if (vdr_en && m_addr == 0 && m_val == 0) begin
                if (cap) begin
                    logic [31:0] w;
                    if (m_fresh) m_ptr = 0;
                    m_fresh = 0;
                    w = word_of(m_ptr / 8);
                    nq.delete();
                    for (int b = 0; b < 4; b++) nq.push_back(w[(m_ptr % 8) * 4 + b]);
                end else if (shf) begin
                    void'(nq.pop_front());
                    nq.push_back(1'b0);
                end else if (upd) begin
                    m_ptr = (m_ptr + 1) % (8 * (NODES + 1));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_tdo;
            logic [NODES-1:0] e_sel, e_upd;
            logic [NODES*MW-1:0] e_nir;
            e_tdo = 1'b0; e_sel = '0;
            if (vir_en) e_tdo = vq[0];
            else if (vdr_en) begin
                if (m_addr == 0) e_tdo = (m_val == 0) ? nq[0] : 1'b0;
                else if (m_addr <= NODES) begin
                    e_tdo = ntdo[m_addr-1];
                    e_sel[m_addr-1] = 1'b1;
                end
            end
            for (int i = 0; i < NODES; i++) begin
                e_upd[i] = m_upd[i];
                e_nir[i*MW +: MW] = MW'(m_nir[i]);
            end
            chk("R2 model tdo", 64'(tdo), 64'(e_tdo));
            chk("R3 model node_ir", 64'(node_ir), 64'(e_nir));
            chk("R3 model node_ir_upd", 64'(node_ir_upd), 64'(e_upd));
            chk("R5 model node_sel", 64'(node_sel), 64'(e_sel));
            chk("R5 model node_tdi", 64'(node_tdi), 64'(tdi));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit c, input bit s, input bit u, input bit t);
        @(posedge clk);
        #1;
        vir_en = md_vir; vdr_en = md_vdr; tlr = md_tlr; ntdo = md_ntdo;
        cap = c; shf = s; upd = u; tdi = t;
        #1;
        last_tdo = tdo;
        last_upd = node_ir_upd;
    endtask

    task automatic vir_scan(input logic [5:0] v, output logic [5:0] got, output logic [NODES-1:0] pulse);
        md_vir = 1; md_vdr = 0;
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 1, 0, v[i]);
            got[i] = last_tdo;
        end
        cyc(0, 0, 1, 0);
        md_vir = 0;
        cyc(0, 0, 0, 0);
        pulse = last_upd;
    endtask

    task automatic nib_scan(output logic [3:0] n);
        md_vdr = 1; md_vir = 0;
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, 0, 0);
            n[i] = last_tdo;
        end
        cyc(0, 0, 1, 0);
        md_vdr = 0;
        cyc(0, 0, 0, 0);
    endtask

    task automatic word_scan(output logic [31:0] w);
        for (int k = 0; k < 8; k++) begin
            logic [3:0] n;
            nib_scan(n);
            w[k*4 +: 4] = n;
        end
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    done = 1;
                    checks++; fails++;
                    $display("FAIL watchdog actual=hung expected=finished");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [5:0] got;
        logic [NODES-1:0] pulse;
        logic [31:0] w;
        logic [3:0] n;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 reset node_ir", 64'(node_ir), 64'h0);
        chk("R1 reset node_ir_upd", 64'(node_ir_upd), 64'h0);
        chk("R10 reset idle tdo", 64'(tdo), 64'h0);

        // R1: reset leaves virtual IR at 0/0
        vir_scan(6'h00, got, pulse);
        chk("R1 vir after reset", 64'(got), 64'h0);

        // R6/R7/R8: full readout and wrap
        nib_scan(n);
        chk("R6 first nibble", 64'(n), 64'(word_of(0) & 32'hF));
        for (int k = 1; k < 8; k++) begin
            logic [3:0] nn;
            nib_scan(nn);
            w[k*4 +: 4] = nn;
        end
        w[3:0] = n;
        chk("R7 config word", 64'(w), 64'(word_of(0)));
        word_scan(w);
        chk("R8 node 1 descriptor", 64'(w), 64'(DESC1));
        word_scan(w);
        chk("R8 node 2 descriptor", 64'(w), 64'(DESC2));
        nib_scan(n);
        chk("R8 wrap to word 0", 64'(n), 64'(word_of(0) & 32'hF));

        // R6 continuation, R9 restart on virtual IR update
        nib_scan(n);
        nib_scan(n);
        chk("R6 continues without reselect", 64'(n), 64'((word_of(0) >> 8) & 32'hF));
        vir_scan(6'h00, got, pulse);
        chk("R4 hub address no strobe", 64'(pulse), 64'h0);
        nib_scan(n);
        chk("R9 restart after vir update", 64'(n), 64'(word_of(0) & 32'hF));

        // R3: node writes
        vir_scan(6'b01_1000, got, pulse);
        chk("R2 capture returns stored vir", 64'(got), 64'h00);
        chk("R3 strobe node 1", 64'(pulse), 64'b01);
        chk("R3 node_ir after node 1", 64'(node_ir), 64'h08);
        vir_scan(6'b10_0101, got, pulse);
        chk("R2 capture returns previous write", 64'(got), 64'b01_1000);
        chk("R3 strobe node 2", 64'(pulse), 64'b10);
        chk("R3 node_ir after node 2", 64'(node_ir), 64'h58);

        // R4: out-of-range and hub addresses
        vir_scan(6'b11_1111, got, pulse);
        chk("R4 addr 3 no strobe", 64'(pulse), 64'h0);
        chk("R4 addr 3 node_ir kept", 64'(node_ir), 64'h58);
        vir_scan(6'b00_0011, got, pulse);
        chk("R2 readback of addr 3 write", 64'(got), 64'b11_1111);
        chk("R4 hub value 3 no strobe", 64'(pulse), 64'h0);
        nib_scan(n);
        chk("R10 hub nonzero value tdo", 64'(n), 64'h0);

        // R5: node data routing
        vir_scan(6'b01_0010, got, pulse);
        md_vdr = 1; md_ntdo = 2'b01;
        cyc(0, 1, 0, 1);
        chk("R5 tdo from node 1", 64'(last_tdo), 64'h1);
        chk("R5 node_sel node 1", 64'(node_sel), 64'b01);
        chk("R5 node_tdi follows tdi", 64'(node_tdi), 64'h1);
        md_ntdo = 2'b10;
        cyc(0, 1, 0, 0);
        chk("R5 tdo ignores other node", 64'(last_tdo), 64'h0);
        md_vdr = 0; md_ntdo = '0;
        cyc(0, 0, 0, 0);
        chk("R5 node_sel idle", 64'(node_sel), 64'h0);

        // R1/R9: Test-Logic-Reset clears vir and restarts readout
        vir_scan(6'h00, got, pulse);
        nib_scan(n);
        nib_scan(n);
        md_tlr = 1;
        cyc(0, 0, 0, 0);
        md_tlr = 0;
        cyc(0, 0, 0, 0);
        nib_scan(n);
        chk("R9 restart after tlr", 64'(n), 64'(word_of(0) & 32'hF));
        vir_scan(6'b10_0001, got, pulse);
        md_tlr = 1;
        cyc(0, 0, 0, 0);
        md_tlr = 0;
        vir_scan(6'h00, got, pulse);
        chk("R1 vir cleared by tlr", 64'(got), 64'h0);
        chk("R3 node_ir kept over tlr", 64'(node_ir), 64'h12);

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule